// File: doc/BRIEF.md
# Parallel Flash Bus Cycle Sequencer

This block sits on the host side of an asynchronous, byte-wide flash memory. It drives the memory's active-low chip enable, output enable, write enable and reset/power-down pins, plus the address bus and a bidirectional data bus split into output, output-enable and input. Every bus cycle is built from clock counts. Each count is derived from a minimum nanosecond timing, divided by the clock period and rounded up. All of these figures are parameters.

A single request port with a valid/ready handshake accepts three kinds of operation, each carrying an address and a data byte:

- a read, which returns one byte;
- a write, which issues one command or data byte;
- a status poll, which repeats read cycles at one address until the device reports ready.

Every operation ends with a one-cycle response pulse that carries a byte, an error flag and a timeout flag. A poll reports failure when any of the three error bits is set in the status byte. A poll gives up with a timeout after a parameterised number of reads.

After its own reset, the block holds the memory's reset pin low for a set time and then releases it. It does not start a write strobe until the memory's write-recovery time has passed. It does not start a read until the longer read-recovery time has passed.

Top module: `pflash_seq`

## Requirements
- R1: While `rstN` is low, and for exactly ceil(T_RSTLOW_NS/CLK_PERIOD_NS) clock cycles after it is released (10 at default values), `flRstN` is low. During that time `flCeN`, `flOeN` and `flWeN` are high, `flDqOe` is low and `reqReady` is low.
- R2: After `flRstN` rises, no write-enable falling edge occurs for at least ceil(T_PS_NS/CLK_PERIOD_NS) cycles (48). No output-enable falling edge occurs for at least ceil(T_PWH_NS/CLK_PERIOD_NS) cycles (60).
- R3: Write strobe framing, with every count rounded up from nanoseconds.
  - Chip enable is low for at least the CS count (1) before write enable falls.
  - Write enable stays low for at least the WP count (5).
  - Address and data are driven and unchanged for at least the AS count (5) before write enable rises.
  - Address, data, data drive and chip enable all remain unchanged just after write enable rises.
- R4: Between write pulses, write enable stays high for at least the WPH count (5). Consecutive write-enable falling edges are at least the WC count (12) apart.
- R5: A read lowers chip enable and output enable together. It samples the data bus only after max(ACC, OE, RC) cycles (12). It returns the sampled byte on `rspData`.
- R6: The host drives the data bus (`flDqOe` high) only while `flOeN` is high. It never does so within the DF count (3) after `flOeN` rises.
- R7: A write completes with a response that has `rspErr` = 0, `rspTimeout` = 0 and `rspData` = 0.
- R8: A poll repeats read cycles at the request address until status bit 7 is 1, so a device that is busy for N reads sees N+1 reads. The response carries the final status byte, with `rspErr` = 1 exactly when any of status bits 3, 4 or 5 is 1. Error bits in a busy status (bit 7 = 0) have no effect.
- R9: If MAX_POLLS status reads all show bit 7 = 0, the poll ends with `rspTimeout` = 1 and `rspErr` = 1, after exactly MAX_POLLS reads.
- R10: The handshake behaves as follows.
  - A request is accepted on a clock edge where `reqValid` and `reqReady` are both high.
  - `reqReady` stays low from acceptance until the response.
  - `rspValid` is high for exactly one cycle per request.
- R11: The `reqOp` encoding is 2'b00 read, 2'b01 write, and 2'b10 or 2'b11 status poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted |
| reqOp | input | 2 | Operation: 00 read, 01 write, 1x poll |
| reqAddr | input | ADDR_W | Request address |
| reqData | input | 8 | Byte to write |
| rspValid | output | 1 | One-cycle completion pulse |
| rspData | output | 8 | Read byte or final status byte, 0 for writes |
| rspErr | output | 1 | Poll error or timeout |
| rspTimeout | output | 1 | Poll ran out of attempts |
| flRstN | output | 1 | Memory reset/power-down, active low |
| flCeN | output | 1 | Memory chip enable, active low |
| flOeN | output | 1 | Memory output enable, active low |
| flWeN | output | 1 | Memory write enable, active low |
| flAddr | output | ADDR_W | Memory address bus |
| flDqOut | output | 8 | Data bus value driven by the host |
| flDqOe | output | 1 | Host data bus drive enable |
| flDqIn | input | 8 | Data bus value seen by the host |

## Verification
The bench pairs the sequencer with a pin-level memory model. The model returns the inverted byte until the chip enable, output enable and reset release have each been active for their full minimum time. A sequencer that samples one cycle early therefore reads a wrong byte. The model also tracks every write strobe edge in cycle counts, so a shortened setup, pulse, hold or recovery shows up as a framing failure. Polls are run against busy phases whose status already carries error bits, against pass and fail final states, and against a device that never becomes ready. This exposes a sequencer that stops on the wrong bit, miscounts attempts, or mixes busy error bits into the verdict. A reset-recovery test that issues a write and then a read straight after reset catches strobes issued too soon after the memory leaves power-down.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [1:0] {
    OP_READ     = 2'b00,
    OP_WRITE    = 2'b01,
    OP_POLL     = 2'b10,
    OP_POLL_ALT = 2'b11
  } opKind_e;

  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
  } padPins_t;

  typedef struct packed {
    padPins_t pads;
    logic     loadReq;
    logic     capture;
  } busCtl_t;

  function automatic int cdiv(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pfs_ctrl.sv
module pfs_ctrl
  import pfs_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_CS_NS       = 10,
  parameter int T_WP_NS       = 50,
  parameter int T_AS_NS       = 50,
  parameter int T_DH_NS       = 10,
  parameter int T_CH_NS       = 10,
  parameter int T_WPH_NS      = 50,
  parameter int T_WC_NS       = 120,
  parameter int T_ACC_NS      = 120,
  parameter int T_OE_NS       = 50,
  parameter int T_RC_NS       = 120,
  parameter int T_DF_NS       = 30,
  parameter int T_PS_NS       = 480,
  parameter int T_PWH_NS      = 600,
  parameter int T_RSTLOW_NS   = 100,
  parameter int MAX_POLLS     = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  output logic       reqReady,
  input  logic       statusReady,
  input  logic       statusFault,
  output busCtl_t    ctl,
  output logic       flRstN,
  output logic       rspValid,
  output logic       rspErr,
  output logic       rspTimeout
);

  localparam int P      = CLK_PERIOD_NS;
  localparam int CS_C   = cdiv(T_CS_NS, P);
  localparam int WP_C   = cdiv(T_WP_NS, P);
  localparam int AS_C   = cdiv(T_AS_NS, P);
  localparam int DH_C   = cdiv(T_DH_NS, P);
  localparam int CH_C   = cdiv(T_CH_NS, P);
  localparam int WPH_C  = cdiv(T_WPH_NS, P);
  localparam int WC_C   = cdiv(T_WC_NS, P);
  localparam int ACC_C  = cdiv(T_ACC_NS, P);
  localparam int OE_C   = cdiv(T_OE_NS, P);
  localparam int RC_C   = cdiv(T_RC_NS, P);
  localparam int DF_C   = cdiv(T_DF_NS, P);
  localparam int PS_C   = cdiv(T_PS_NS, P);
  localparam int PWH_C  = cdiv(T_PWH_NS, P);
  localparam int RSTL_C = imax(cdiv(T_RSTLOW_NS, P), 1);

  localparam int SET_C  = imax(CS_C, imax(AS_C - WP_C, 1));
  localparam int WPU_C  = imax(WP_C, 1);
  localparam int HLD_C  = imax(imax(DH_C, CH_C), 1);
  localparam int REC_C  = imax(1, imax(WC_C - SET_C - WPU_C - HLD_C, WPH_C - HLD_C - SET_C));
  localparam int ACCT_C = imax(imax(ACC_C, OE_C), imax(RC_C, 1));
  localparam int FLT_C  = imax(DF_C, 1);
  localparam int WAKE_C = imax(PS_C, PWH_C);
  localparam int MAXC   = imax(imax(WAKE_C, ACCT_C), imax(imax(REC_C, RSTL_C), imax(imax(SET_C, WPU_C), imax(HLD_C, FLT_C))));
  localparam int CW     = $clog2(MAXC + 2) + 1;
  localparam int PW     = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {
    ST_RST, ST_IDLE, ST_WSET, ST_WPUL, ST_WHLD, ST_WREC, ST_RACC, ST_RFLT
  } seqState_e;

  seqState_e st, stNext;
  logic [CW-1:0] cnt, cntNext;
  logic [CW-1:0] rstCnt;
  logic [CW-1:0] wakeCnt;
  logic [CW-1:0] weLowCnt;
  logic [PW-1:0] pollCnt, pollNext;
  logic          isPoll, isPollNext;
  logic          fire, errNext, toNext, loadReq, capture;
  padPins_t      padQ;
  logic          flRstNQ;

  function automatic padPins_t decodePads(input seqState_e s);
    padPins_t p;
    p = '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, drive: 1'b0};
    case (s)
      ST_WSET: begin p.ceN = 1'b0; p.drive = 1'b1; end
      ST_WPUL: begin p.ceN = 1'b0; p.weN = 1'b0; p.drive = 1'b1; end
      ST_WHLD: begin p.ceN = 1'b0; p.drive = 1'b1; end
      ST_RACC: begin p.ceN = 1'b0; p.oeN = 1'b0; end
      default: ;
    endcase
    return p;
  endfunction

  always_comb begin
    if (st != ST_IDLE) begin
      reqReady = 1'b0;
    end else if (opKind_e'(reqOp) == OP_WRITE) begin
      reqReady = (wakeCnt >= CW'(PS_C));
    end else begin
      reqReady = (wakeCnt >= CW'(PWH_C));
    end
  end

  always_comb begin
    stNext     = st;
    cntNext    = (cnt != '0) ? cnt - 1'b1 : cnt;
    pollNext   = pollCnt;
    isPollNext = isPoll;
    fire       = 1'b0;
    errNext    = 1'b0;
    toNext     = 1'b0;
    loadReq    = 1'b0;
    capture    = 1'b0;
    case (st)
      ST_RST: begin
        if (rstCnt == CW'(RSTL_C)) stNext = ST_IDLE;
      end
      ST_IDLE: begin
        if (reqValid && reqReady) begin
          loadReq    = 1'b1;
          pollNext   = '0;
          isPollNext = reqOp[1];
          if (opKind_e'(reqOp) == OP_WRITE) begin
            stNext  = ST_WSET;
            cntNext = CW'(SET_C - 1);
          end else begin
            stNext  = ST_RACC;
            cntNext = CW'(ACCT_C - 1);
          end
        end
      end
      ST_WSET: if (cnt == '0) begin stNext = ST_WPUL; cntNext = CW'(WPU_C - 1); end
      ST_WPUL: if (cnt == '0) begin stNext = ST_WHLD; cntNext = CW'(HLD_C - 1); end
      ST_WHLD: if (cnt == '0) begin stNext = ST_WREC; cntNext = CW'(REC_C - 1); end
      ST_WREC: if (cnt == '0) begin stNext = ST_IDLE; fire = 1'b1; end
      ST_RACC: begin
        if (cnt == '0) begin
          capture = 1'b1;
          stNext  = ST_RFLT;
          cntNext = CW'(FLT_C - 1);
        end
      end
      ST_RFLT: begin
        if (cnt == '0) begin
          if (!isPoll) begin
            stNext = ST_IDLE;
            fire   = 1'b1;
          end else if (statusReady) begin
            stNext  = ST_IDLE;
            fire    = 1'b1;
            errNext = statusFault;
          end else if (pollCnt == PW'(MAX_POLLS - 1)) begin
            stNext  = ST_IDLE;
            fire    = 1'b1;
            errNext = 1'b1;
            toNext  = 1'b1;
          end else begin
            pollNext = pollCnt + 1'b1;
            stNext   = ST_RACC;
            cntNext  = CW'(ACCT_C - 1);
          end
        end
      end
      default: stNext = ST_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_RST;
      cnt        <= '0;
      rstCnt     <= '0;
      wakeCnt    <= '0;
      weLowCnt   <= '0;
      pollCnt    <= '0;
      isPoll     <= 1'b0;
      flRstNQ    <= 1'b0;
      padQ       <= '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, drive: 1'b0};
      rspValid   <= 1'b0;
      rspErr     <= 1'b0;
      rspTimeout <= 1'b0;
    end else begin
      st      <= stNext;
      cnt     <= cntNext;
      pollCnt <= pollNext;
      isPoll  <= isPollNext;
      if (st == ST_RST) rstCnt <= rstCnt + 1'b1;
      flRstNQ <= (stNext != ST_RST);
      if (flRstNQ && wakeCnt != CW'(WAKE_C)) wakeCnt <= wakeCnt + 1'b1;
      if (padQ.weN) weLowCnt <= '0;
      else if (weLowCnt != CW'(MAXC)) weLowCnt <= weLowCnt + 1'b1;
      padQ       <= decodePads(stNext);
      rspValid   <= fire;
      rspErr     <= errNext;
      rspTimeout <= toNext;
    end
  end

  assign flRstN       = flRstNQ;
  assign ctl.pads     = padQ;
  assign ctl.loadReq  = loadReq;
  assign ctl.capture  = capture;

  AST_RST_PADS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !flRstN |-> (padQ.ceN && padQ.oeN && padQ.weN && !padQ.drive)); // R1
  AST_WAKE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(padQ.weN) |-> (wakeCnt >= CW'(PS_C))); // R2
  AST_WAKE_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(padQ.oeN) |-> (wakeCnt >= CW'(PWH_C))); // R2
  AST_CE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(padQ.weN) |-> $past(!padQ.ceN)); // R3
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(padQ.weN) |-> (weLowCnt >= CW'(WPU_C))); // R3
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R10
  AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PW'(MAX_POLLS)); // R9
  AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (!rstN)
    rspTimeout |-> (rspErr && rspValid)); // R9

endmodule

// File: rtl/pfs_dpath.sv
module pfs_dpath
  import pfs_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int BUS_TURN_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [7:0]        flDqIn,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDqOut,
  output logic              flDqOe,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN,
  output logic              statusReady,
  output logic              statusFault,
  output logic [7:0]        rspData
);

  localparam int TW = $clog2(BUS_TURN_CYC + 2) + 1;

  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic [7:0]        capQ;
  logic [TW-1:0]     oeHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      capQ  <= '0;
    end else begin
      if (ctl.loadReq) begin
        addrQ <= reqAddr;
        dataQ <= reqData;
        capQ  <= '0;
      end else if (ctl.capture) begin
        capQ <= flDqIn;
      end
    end
  end

  assign flAddr      = addrQ;
  assign flDqOut     = dataQ;
  assign flCeN       = ctl.pads.ceN;
  assign flOeN       = ctl.pads.oeN;
  assign flWeN       = ctl.pads.weN;
  assign flDqOe      = ctl.pads.drive & ctl.pads.oeN;
  assign statusReady = capQ[7];
  assign statusFault = |capQ[5:3];
  assign rspData     = capQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeHighCnt <= '0;
    end else if (!flOeN) begin
      oeHighCnt <= '0;
    end else if (oeHighCnt != TW'(BUS_TURN_CYC + 1)) begin
      oeHighCnt <= oeHighCnt + 1'b1;
    end
  end

  AST_BUS_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flDqOe) |-> (oeHighCnt >= TW'(BUS_TURN_CYC))); // R6
  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN && $past(!flWeN)) |-> ($stable(flAddr) && $stable(flDqOut))); // R3

endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
  import pfs_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_CS_NS       = 10,
  parameter int T_WP_NS       = 50,
  parameter int T_AS_NS       = 50,
  parameter int T_DH_NS       = 10,
  parameter int T_CH_NS       = 10,
  parameter int T_WPH_NS      = 50,
  parameter int T_WC_NS       = 120,
  parameter int T_ACC_NS      = 120,
  parameter int T_OE_NS       = 50,
  parameter int T_RC_NS       = 120,
  parameter int T_DF_NS       = 30,
  parameter int T_PS_NS       = 480,
  parameter int T_PWH_NS      = 600,
  parameter int T_RSTLOW_NS   = 100,
  parameter int MAX_POLLS     = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              rspValid,
  output logic [7:0]        rspData,
  output logic              rspErr,
  output logic              rspTimeout,
  output logic              flRstN,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDqOut,
  output logic              flDqOe,
  input  logic [7:0]        flDqIn
);

  localparam int TURN_C = imax(cdiv(T_DF_NS, CLK_PERIOD_NS), 1);

  busCtl_t ctl;
  logic    statusReady;
  logic    statusFault;

  pfs_ctrl #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_CS_NS(T_CS_NS), .T_WP_NS(T_WP_NS),
    .T_AS_NS(T_AS_NS), .T_DH_NS(T_DH_NS), .T_CH_NS(T_CH_NS),
    .T_WPH_NS(T_WPH_NS), .T_WC_NS(T_WC_NS), .T_ACC_NS(T_ACC_NS),
    .T_OE_NS(T_OE_NS), .T_RC_NS(T_RC_NS), .T_DF_NS(T_DF_NS),
    .T_PS_NS(T_PS_NS), .T_PWH_NS(T_PWH_NS), .T_RSTLOW_NS(T_RSTLOW_NS),
    .MAX_POLLS(MAX_POLLS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqReady(reqReady), .statusReady(statusReady), .statusFault(statusFault),
    .ctl(ctl), .flRstN(flRstN), .rspValid(rspValid), .rspErr(rspErr),
    .rspTimeout(rspTimeout)
  );

  pfs_dpath #(
    .ADDR_W(ADDR_W), .BUS_TURN_CYC(TURN_C)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqData(reqData),
    .flDqIn(flDqIn), .flAddr(flAddr), .flDqOut(flDqOut), .flDqOe(flDqOe),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN), .statusReady(statusReady),
    .statusFault(statusFault), .rspData(rspData)
  );

endmodule

// File: tb/test_pflash_seq.sv
module test_pflash_seq;

  localparam int AW    = 17;
  localparam int RSTL  = 10;
  localparam int PS    = 48;
  localparam int PWH   = 60;
  localparam int CS    = 1;
  localparam int WP    = 5;
  localparam int AS    = 5;
  localparam int WPH   = 5;
  localparam int WC    = 12;
  localparam int ACC   = 12;
  localparam int OEC   = 5;
  localparam int DF    = 3;
  localparam int MAXP  = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqOp = 2'b00;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqData = '0;
  logic          rspValid, rspErr, rspTimeout;
  logic [7:0]    rspData;
  logic          flRstN, flCeN, flOeN, flWeN, flDqOe;
  logic [AW-1:0] flAddr;
  logic [7:0]    flDqOut;
  logic [7:0]    flDqIn = 8'h00;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pflash_seq i_pflash_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .rspValid(rspValid),
    .rspData(rspData), .rspErr(rspErr), .rspTimeout(rspTimeout),
    .flRstN(flRstN), .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN),
    .flAddr(flAddr), .flDqOut(flDqOut), .flDqOe(flDqOe), .flDqIn(flDqIn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- pin-level memory model ----------------
  logic [7:0] mem [16];
  logic [7:0] shadow [16];
  bit         statusMode = 1'b0;
  int         busyLeft = 0;
  logic [7:0] finalStat = 8'h80;
  int         statReads = 0;
  int         contErr = 0;

  logic          pCe = 1'b1, pOe = 1'b1, pWe = 1'b1, pDqOe = 1'b0;
  logic [AW-1:0] pAddr = '0;
  logic [7:0]    pDq = '0;
  int ceLow = 0, oeLow = 0, oeHigh = 100, weLow = 0, weHigh = 100;
  int sinceFall = 100, stab = 0, rstHigh = 0;
  bit seenFall = 1'b0;

  function automatic logic [7:0] modelValue(input logic [AW-1:0] a);
    if (statusMode) return (busyLeft > 0) ? 8'h38 : finalStat;
    return mem[a[3:0]];
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      ceLow = 0; oeLow = 0; oeHigh = 100; weLow = 0; weHigh = 100;
      sinceFall = 100; stab = 0; rstHigh = 0; seenFall = 1'b0;
    end else begin
      if (pWe && !flWeN) begin
        chk(ceLow >= CS, "R3 chip enable before write strobe", ceLow, CS);
        chk(rstHigh >= PS, "R2 write after reset release", rstHigh, PS);
        if (seenFall) begin
          chk(weHigh >= WPH, "R4 write enable high time", weHigh, WPH);
          chk(sinceFall >= WC, "R4 write cycle length", sinceFall, WC);
        end
        seenFall = 1'b1;
        sinceFall = 0;
      end
      if (!pWe && flWeN) begin
        chk(weLow >= WP, "R3 write strobe width", weLow, WP);
        chk(stab >= AS, "R3 address/data setup", stab, AS);
        chk(!flCeN && flDqOe && flAddr == pAddr && flDqOut == pDq,
            "R3 hold after strobe", int'(flDqOut), int'(pDq));
        if (!statusMode) mem[pAddr[3:0]] = pDq;
      end
      if (pOe && !flOeN) begin
        chk(!flCeN && pCe, "R5 chip and output enable together", int'(flCeN), 0);
        chk(rstHigh >= PWH, "R2 read after reset release", rstHigh, PWH);
      end
      if (!pOe && flOeN && statusMode) begin
        statReads++;
        if (busyLeft > 0) busyLeft--;
      end
      if (flDqOe && (!flOeN || oeHigh < DF)) contErr++;
      stab = (!flCeN && flDqOe) ? ((flAddr == pAddr && flDqOut == pDq && pDqOe) ? stab + 1 : 1) : 0;
      ceLow = flCeN ? 0 : ceLow + 1;
      oeLow = flOeN ? 0 : oeLow + 1;
      oeHigh = flOeN ? oeHigh + 1 : 0;
      weLow = flWeN ? 0 : weLow + 1;
      weHigh = flWeN ? weHigh + 1 : 0;
      sinceFall++;
      rstHigh = flRstN ? rstHigh + 1 : 0;
    end
    begin
      logic [7:0] v;
      v = modelValue(flAddr);
      flDqIn = (!flCeN && !flOeN && ceLow >= ACC && oeLow >= OEC && rstHigh >= PWH) ? v : ~v;
    end
    pCe = flCeN; pOe = flOeN; pWe = flWeN; pDqOe = flDqOe;
    pAddr = flAddr; pDq = flDqOut;
  end

  // ---------------- request driver ----------------
  task automatic doOp(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output logic e, output logic t);
    bit busyBad;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqData = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1 reqValid = 1'b0;
    busyBad = 1'b0;
    @(negedge clk);
    while (!rspValid) begin
      if (reqReady) busyBad = 1'b1;
      @(negedge clk);
    end
    rd = rspData; e = rspErr; t = rspTimeout;
    chk(!busyBad, "R10 ready low while busy", int'(busyBad), 0);
    @(negedge clk);
    chk(!rspValid, "R10 single-cycle response", int'(rspValid), 0);
  endtask

  task automatic doReset();
    int lowCnt;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!flRstN, "R1 reset pin low in reset", int'(flRstN), 0);
    chk(flCeN && flOeN && flWeN, "R1 strobes idle in reset", int'({flCeN, flOeN, flWeN}), 7);
    chk(!flDqOe && !reqReady, "R1 no drive, not ready", int'({flDqOe, reqReady}), 0);
    rstN = 1'b1;
    lowCnt = 0;
    @(negedge clk);
    while (!flRstN && lowCnt < 1000) begin
      lowCnt++;
      if (!flCeN || !flWeN || !flOeN || reqReady) begin
        chk(1'b0, "R1 strobes idle while reset pin low", 1, 0);
      end
      @(negedge clk);
    end
    chk(lowCnt == RSTL, "R1 reset pin low time", lowCnt, RSTL);
  endtask

  function automatic bit faultOf(input logic [7:0] s);
    return |s[5:3];
  endfunction

  task automatic doPoll(input logic [1:0] op, input int busy, input logic [7:0] fin);
    logic [7:0] rd; logic e, t;
    statusMode = 1'b1; busyLeft = busy; finalStat = fin; statReads = 0;
    doOp(op, AW'($urandom), 8'h00, rd, e, t);
    chk(rd == fin, "R8 final status byte", int'(rd), int'(fin));
    chk(e == faultOf(fin) && !t, "R8 poll error flag", int'({e, t}), int'({faultOf(fin), 1'b0}));
    chk(statReads == busy + 1, "R8 poll read count", statReads, busy + 1);
    statusMode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd; logic e, t;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end

    // R1, R2: reset then an immediate write
    doReset();
    doOp(2'b01, AW'(5), 8'h5A, rd, e, t);
    shadow[5] = 8'h5A;
    chk(rd == 8'h00 && !e && !t, "R7 write response", int'({rd, e, t}), 0);

    // R2: reset then an immediate read
    doReset();
    doOp(2'b00, AW'(5), 8'h00, rd, e, t);
    chk(rd == shadow[5] && !e && !t, "R5 read after reset", int'(rd), int'(shadow[5]));

    // back-to-back writes then reads (R4, R5)
    for (int i = 0; i < 4; i++) begin
      doOp(2'b01, AW'(i), 8'(8'hC0 + i), rd, e, t);
      shadow[i] = 8'(8'hC0 + i);
    end
    for (int i = 0; i < 4; i++) begin
      doOp(2'b00, AW'(i), 8'hFF, rd, e, t);
      chk(rd == shadow[i], "R5 read data", int'(rd), int'(shadow[i]));
    end

    // random mix of reads and writes (R5, R7, R11)
    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'($urandom);
      d = 8'($urandom);
      if ($urandom_range(1, 0) == 1) begin
        doOp(2'b01, a, d, rd, e, t);
        shadow[a[3:0]] = d;
        chk(rd == 8'h00 && !e && !t, "R7 write response", int'({rd, e, t}), 0);
      end else begin
        doOp(2'b00, a, d, rd, e, t);
        chk(rd == shadow[a[3:0]] && !e && !t, "R5 read data", int'(rd), int'(shadow[a[3:0]]));
      end
    end

    // directed polls (R8, R11): ready at once, busy with error bits, fail states
    doPoll(2'b10, 0, 8'h80);
    doPoll(2'b11, 3, 8'h80);
    doPoll(2'b10, 2, 8'h90);
    doPoll(2'b11, 1, 8'hA8);
    doPoll(2'b10, 4, 8'hC7);
    for (int n = 0; n < 8; n++) begin
      doPoll(($urandom_range(1, 0) == 1) ? 2'b11 : 2'b10, int'($urandom_range(6, 0)),
             8'(8'h80 | ($urandom & 32'h7F)));
    end

    // R9: device never ready
    statusMode = 1'b1; busyLeft = 1000000; finalStat = 8'h80; statReads = 0;
    doOp(2'b10, AW'(9), 8'h00, rd, e, t);
    chk(t && e, "R9 timeout flags", int'({t, e}), 3);
    chk(statReads == MAXP, "R9 poll attempts", statReads, MAXP);
    statusMode = 1'b0;

    // memory untouched by polls, and read after timeout
    doOp(2'b00, AW'(5), 8'h00, rd, e, t);
    chk(rd == shadow[5] && !t, "R5 read after timeout", int'(rd), int'(shadow[5]));

    chk(contErr == 0, "R6 bus turnaround", contErr, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule